// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block keeps one use bit for each of a fixed number of physical frames and chooses a frame to evict when a page fault needs a free slot. Any reference to a frame sets its bit, and so does loading a page into it. A circular hand pointer marks the next eviction candidate. The block serves a victim request by moving the hand forward one frame per clock cycle. A frame whose bit is set gets a second chance: the block clears its bit and steps past it. The first frame found with a clear bit becomes the victim. The result approximates least-recently-used replacement at the cost of one bit per frame.

A fault handler raises `vic_req` for one cycle. It waits for `vic_done`, reads `vic_idx`, loads the new page into that frame and reports the load on the fill port. References from the translation path arrive on the reference port at any time, including during a scan.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all use bits are 0, the hand points at frame 0, `vic_done` is 0 and `vic_idx` is 0.
- R2: A cycle with `ref_valid` high sets the use bit of frame `ref_frame` to 1.
- R3: During a scan, if the frame under the hand has use bit 0, that frame is returned on `vic_idx`. The hand then points one frame further on, so the next scan starts there.
- R4: During a scan, if the frame under the hand has use bit 1, the bit is cleared, the hand advances by one and the scan goes on in the next cycle.
- R5: The hand moves from frame FRAMES-1 to frame 0.
- R6: A cycle with `fill_valid` high sets the use bit of frame `fill_frame` to 1.
- R7: If a reference or fill hits the frame under the hand in the same cycle that the scan examines it, the bit stays 1 and the frame is not chosen.
- R8: If no reference or fill arrives during a scan, the victim is found within FRAMES+1 examined frames. The first frame is examined on the edge after the request is accepted.
- R9: An accepted request drops `vic_done` on the next edge. A request that arrives while a scan is running is ignored. While `vic_done` is high and no new request arrives, `vic_idx` and `vic_done` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Frame reference strobe |
| ref_frame | input | IW | Index of the referenced frame |
| fill_valid | input | 1 | Frame loaded strobe |
| fill_frame | input | IW | Index of the loaded frame |
| vic_req | input | 1 | Start a victim search (accepted when idle) |
| vic_idx | output | IW | Chosen victim frame |
| vic_done | output | 1 | Victim valid; held until the next accepted request |

## Verification
The bench builds the block with the default of four frames. With four frames a wrap of the hand happens every few requests. A worst-case scan, in which every bit is set, costs only five examined frames, so the FRAMES+1 bound can be checked to the exact cycle. The small size also makes it cheap to set up a reference that collides with the scan on the frame under the hand. Every use-bit pattern that the vector table produces can be predicted by hand.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // Index of the next frame around the ring of n frames.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/use_bit_array.sv
module use_bit_array #(
    parameter int FRAMES = 4,
    parameter int IW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [IW-1:0]     ref_frame,
    input  logic              fill_valid,
    input  logic [IW-1:0]     fill_frame,
    input  logic              clr_en,
    input  logic [IW-1:0]     clr_frame,
    output logic [FRAMES-1:0] bits
);

    for (genvar g = 0; g < FRAMES; g++) begin : g_frame
        logic touch, wipe;
        assign touch = (ref_valid && ref_frame == IW'(g)) || (fill_valid && fill_frame == IW'(g));
        assign wipe  = clr_en && clr_frame == IW'(g);

        always_ff @(posedge clk) begin
            if (rst)        bits[g] <= 1'b0;
            else if (touch) bits[g] <= 1'b1;
            else if (wipe)  bits[g] <= 1'b0;
        end
    end

    a_r2_ref_sets: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> bits[$past(ref_frame)]);

    a_r6_fill_sets: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> bits[$past(fill_frame)]);

    a_r7_touch_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_en && ref_valid && ref_frame == clr_frame) |=> bits[$past(clr_frame)]);

    a_r4_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(ref_valid && ref_frame == clr_frame) && !(fill_valid && fill_frame == clr_frame))
        |=> !bits[$past(clr_frame)]);

endmodule

// File: rtl/hand_pointer.sv
module hand_pointer #(
    parameter int FRAMES = 4,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] hand
);
    import clk_repl_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)      hand <= '0;
        else if (adv) hand <= IW'(ring_next(int'(hand), FRAMES));
    end

    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && hand == IW'(FRAMES - 1)) |=> hand == '0);

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(hand));

    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(hand) < FRAMES);

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
    parameter int FRAMES = 4,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vic_req,
    input  logic [IW-1:0] hand,
    input  logic          use_cur,
    input  logic          touch_cur,
    input  logic          any_touch,
    output logic          clr_en,
    output logic          adv,
    output logic [IW-1:0] vic_idx,
    output logic          vic_done
);
    import clk_repl_pkg::*;

    localparam int CW = $clog2(FRAMES + 2);

    scan_state_e state;
    logic        taken;

    assign taken  = (state == ST_SCAN) && !use_cur && !touch_cur;
    assign adv    = (state == ST_SCAN);
    assign clr_en = (state == ST_SCAN) && !taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            vic_idx  <= '0;
            vic_done <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (vic_req) begin
                    state    <= ST_SCAN;
                    vic_done <= 1'b0;
                end
                ST_SCAN: if (taken) begin
                    state    <= ST_IDLE;
                    vic_idx  <= hand;
                    vic_done <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: number of frames already examined in this scan.
    logic [CW-1:0] seen;
    logic          disturbed;
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            seen      <= '0;
            disturbed <= 1'b0;
        end else begin
            seen      <= seen + 1'b1;
            disturbed <= disturbed || any_touch;
        end
    end

    a_r8_bounded_scan: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN && !disturbed && !any_touch) |-> int'(seen) <= FRAMES);

    a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
        (vic_done && !vic_req) |=> vic_done && $stable(vic_idx));

    a_r9_done_drops: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && vic_req) |=> !vic_done);

    a_r3_pick_is_hand: assert property (@(posedge clk) disable iff (rst)
        taken |=> vic_done && vic_idx == $past(hand));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int FRAMES = 4,
    parameter int IW     = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_valid,
    input  logic [IW-1:0] ref_frame,
    input  logic          fill_valid,
    input  logic [IW-1:0] fill_frame,
    input  logic          vic_req,
    output logic [IW-1:0] vic_idx,
    output logic          vic_done
);

    logic [FRAMES-1:0] bits;
    logic [IW-1:0]     hand;
    logic              clr_en, adv, touch_cur, use_cur, any_touch;

    assign use_cur   = bits[hand];
    assign touch_cur = (ref_valid && ref_frame == hand) || (fill_valid && fill_frame == hand);
    assign any_touch = ref_valid || fill_valid;

    use_bit_array #(.FRAMES(FRAMES), .IW(IW)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .ref_valid (ref_valid),
        .ref_frame (ref_frame),
        .fill_valid(fill_valid),
        .fill_frame(fill_frame),
        .clr_en    (clr_en),
        .clr_frame (hand),
        .bits      (bits)
    );

    hand_pointer #(.FRAMES(FRAMES), .IW(IW)) u_hand (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .hand(hand)
    );

    scan_ctrl #(.FRAMES(FRAMES), .IW(IW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .vic_req  (vic_req),
        .hand     (hand),
        .use_cur  (use_cur),
        .touch_cur(touch_cur),
        .any_touch(any_touch),
        .clr_en   (clr_en),
        .adv      (adv),
        .vic_idx  (vic_idx),
        .vic_done (vic_done)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> !vic_done && vic_idx == '0 && bits == '0 && hand == '0);

endmodule

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;

    localparam int FRAMES = 4;
    localparam int IW     = 2;

    // Vector table: op 0 = reference, 1 = fill, 2 = victim request.
    localparam int NV = 13;
    localparam int OPS [NV] = '{2, 1, 2, 1, 0, 2, 1, 2, 1, 0, 0, 2, 2};
    localparam int ARG [NV] = '{0, 0, 0, 1, 2, 0, 3, 0, 2, 0, 1, 0, 0};
    localparam int EVIC[NV] = '{0, 0, 1, 0, 0, 3, 0, 2, 0, 0, 0, 3, 0};
    localparam int ECYC[NV] = '{1, 0, 1, 0, 0, 2, 0, 3, 0, 0, 0, 5, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_frame = '0;
    logic          vic_req = 1'b0;
    logic [IW-1:0] vic_idx;
    logic          vic_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clock_victim_sel #(.FRAMES(FRAMES)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ref_valid (ref_valid),
        .ref_frame (ref_frame),
        .fill_valid(fill_valid),
        .fill_frame(fill_frame),
        .vic_req   (vic_req),
        .vic_idx   (vic_idx),
        .vic_done  (vic_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic touch(input bit is_fill, input int f);
        @(negedge clk);
        if (is_fill) begin fill_valid = 1'b1; fill_frame = IW'(f); end
        else         begin ref_valid  = 1'b1; ref_frame  = IW'(f); end
        @(negedge clk);
        fill_valid = 1'b0;
        ref_valid  = 1'b0;
    endtask

    task automatic request(input bit with_ref, input int rf, input bit extra_req,
                           output int vic, output int cyc);
        @(negedge clk);
        vic_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vic_req = 1'b0;
        check("R9 done drops after accept", int'(vic_done), 0);
        if (with_ref) begin ref_valid = 1'b1; ref_frame = IW'(rf); end
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            ref_valid = 1'b0;
            vic_req   = (extra_req && cyc == 1);
            if (vic_done || cyc > 40) break;
        end
        vic_req = 1'b0;
        vic = int'(vic_idx);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int v, c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the outputs
        check("R1 done after reset", int'(vic_done), 0);
        check("R1 victim after reset", int'(vic_idx), 0);

        // Vector walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            if (OPS[i] == 2) begin
                request(1'b0, 0, 1'b0, v, c);
                check($sformatf("R3/R4/R5 vector %0d victim", i), v, EVIC[i]);
                check($sformatf("R8 vector %0d scan cycles", i), c, ECYC[i]);
            end else begin
                touch(OPS[i] == 1, ARG[i]);
            end
        end

        // R9: result holds while done and no new request
        repeat (3) @(negedge clk);
        check("R9 done held", int'(vic_done), 1);
        check("R9 victim held", int'(vic_idx), 0);

        // R9: second request mid-scan ignored; hand=1, all bits set -> victim 1 after 5
        for (int f = 0; f < FRAMES; f++) touch(1'b1, f);
        request(1'b0, 0, 1'b1, v, c);
        check("R9 mid-scan request ignored victim", v, 1);
        check("R9 mid-scan request ignored cycles", c, 5);
        @(negedge clk);
        check("R9 no restart after ignored request", int'(vic_done), 1);

        // R7: hand=2, bits all 0; reference to frame 2 collides with first examine
        request(1'b1, 2, 1'b0, v, c);
        check("R7 collided frame skipped victim", v, 3);
        check("R7 collided frame skipped cycles", c, 2);
        // Frame 2 must have kept its bit: set 0,1,3 -> all set -> full sweep from 0
        touch(1'b1, 0);
        touch(1'b1, 1);
        touch(1'b0, 3);
        request(1'b0, 0, 1'b0, v, c);
        check("R7 bit kept after collision victim", v, 0);
        check("R7 bit kept after collision cycles", c, 5);

        // R1: reset mid-result clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 done after second reset", int'(vic_done), 0);
        request(1'b0, 0, 1'b0, v, c);
        check("R1 hand back at frame 0", v, 0);
        check("R1 bits cleared by reset", c, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule